// File: doc/BRIEF.md
# Far-End Block Error Bit Selector

This block produces the far-end block error bit sent once per superframe. At each superframe boundary it combines two sources under software control. The first is the near-end block error result found locally in the superframe that is ending. The second is a forwarded-error bit that software writes to pass on an adjacent section's result. Separate enables decide whether each source takes part. A run control can pin the outgoing bit low for test.

The output is a register that changes only on the boundary strobe. It then holds that value for the whole of the following superframe. The forwarded-error bit is a one-shot. A 0 written by software is used at the next boundary, and the bit then returns to 1 by itself. Software never has to restore it.

Top module: `febe_sel`

## Requirements
- R1: After reset, `febe_o` is 1. The run control, the local enable, the remote enable and the forwarded-error bit all start at 1.
- R2: `febe_o` changes only on a clock edge where `sf_strobe` is 1. Changes to `nebe_i` or to the control bits between strobes leave it unchanged.
- R3: If the run control (`ctl_wdata[0]`) is 0 at a boundary, `febe_o` becomes 0 whatever the other inputs are.
- R4: When the remote enable (`ctl_wdata[1]`) is 1, the forwarded-error bit takes part in the result. When it is 0, the forwarded-error bit has no effect on `febe_o`.
- R5: When the local enable (`ctl_wdata[2]`) is 1, `nebe_i` sampled at the boundary takes part in the result. When it is 0, `nebe_i` has no effect on `febe_o`.
- R6: With all three control bits at 1, `febe_o` after a boundary equals `nebe_i` OR the forwarded-error bit, both as held at that boundary.
- R7: With the run control at 1 and both enables at 0, `febe_o` becomes 1 at the boundary.
- R8: A forwarded-error bit written as 0 is used at the next boundary only. The bit is then 1 again with no software write.
- R9: If a forwarded-error write lands in the same cycle as a strobe, that strobe uses the previous value. The written value is used at the following boundary.
- R10: A control write takes effect at the first boundary after the write, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_wdata | input | 3 | Control bits: [0] run, [1] remote enable, [2] local enable |
| fwd_we | input | 1 | Write strobe for the forwarded-error bit |
| fwd_wdata | input | 1 | Forwarded-error value to store |
| sf_strobe | input | 1 | One-cycle superframe boundary pulse |
| nebe_i | input | 1 | Near-end block error result of the ending superframe |
| febe_o | output | 1 | Far-end block error bit for the coming superframe |

## Verification
The assertions assume that `sf_strobe` is a single-cycle pulse. They also assume that `nebe_i` is valid in the cycle of that pulse and that writes are single-cycle strobes. They treat a write that coincides with a strobe as legal.

The stimulus drives every input on the falling clock edge. It raises `sf_strobe` for exactly one cycle at a time. It sweeps all eight control codes against both `nebe_i` values and both forwarded-error values, and it includes a write that lands in the same cycle as a strobe.

// File: rtl/febe_sel_pkg.sv
package febe_sel_pkg;

  // Control word; bit order matches the write data bus.
  typedef struct packed {
    logic lcl_en;   // [2] local (near-end) source enable
    logic rmt_en;   // [1] remote (forwarded) source enable
    logic run;      // [0] 0 pins the output low
  } febe_ctl_t;

  localparam int unsigned CTL_W = $bits(febe_ctl_t);
  localparam febe_ctl_t   CTL_RESET = '{lcl_en: 1'b1, rmt_en: 1'b1, run: 1'b1};

  // Selection rule for the outgoing bit.
  function automatic logic febe_pick(febe_ctl_t c, logic nebe, logic fwd);
    if (!c.run) return 1'b0;
    if (!c.lcl_en && !c.rmt_en) return 1'b1;
    return (c.lcl_en & nebe) | (c.rmt_en & fwd);
  endfunction

endpackage

// File: rtl/febe_ctl_reg.sv
module febe_ctl_reg
  import febe_sel_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [CTL_W-1:0]     ctl_wdata,
  output febe_ctl_t            ctl_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= CTL_RESET;
    else if (ctl_we) ctl_q <= febe_ctl_t'(ctl_wdata);
  end

  // R10: a write lands in the stored control word one cycle later
  p_ctl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_q == febe_ctl_t'($past(ctl_wdata))));

  // R10: without a write the control word holds
  p_ctl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_q));

endmodule

// File: rtl/febe_fwd_bit.sv
module febe_fwd_bit #(
  parameter logic REST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_we,
  input  logic fwd_wdata,
  input  logic sf_strobe,
  output logic fwd_q,
  output logic fwd_consumed
);

  // The bit is used up at a boundary unless a fresh write arrives together.
  assign fwd_consumed = sf_strobe && !fwd_we;

  always_ff @(posedge clk) begin
    if (!rst_n)            fwd_q <= REST_VAL;
    else if (fwd_we)       fwd_q <= fwd_wdata;
    else if (fwd_consumed) fwd_q <= REST_VAL;
  end

  // R8: after a boundary with no write the bit is back at its rest value
  p_fwd_rest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_consumed |=> (fwd_q == REST_VAL));

  // R9: a write always wins, even against a boundary in the same cycle
  p_fwd_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_we |=> (fwd_q == $past(fwd_wdata)));

endmodule

// File: rtl/febe_out_stage.sv
module febe_out_stage
  import febe_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sf_strobe,
  input  febe_ctl_t ctl,
  input  logic      nebe,
  input  logic      fwd,
  output logic      febe_q
);

  logic febe_next;
  assign febe_next = febe_pick(ctl, nebe, fwd);

  always_ff @(posedge clk) begin
    if (!rst_n)         febe_q <= 1'b1;
    else if (sf_strobe) febe_q <= febe_next;
  end

  // R2: no boundary, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_strobe |=> $stable(febe_q));

  // R3: run control low forces a zero
  p_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_strobe && !ctl.run) |=> !febe_q);

  // R7: both sources disabled reports no error
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_strobe && ctl.run && !ctl.lcl_en && !ctl.rmt_en) |=> febe_q);

  // R6: with everything enabled, either source raises the bit
  p_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_strobe && ctl.run && ctl.lcl_en && ctl.rmt_en && (nebe || fwd)) |=> febe_q);

endmodule

// File: rtl/febe_sel.sv
module febe_sel
  import febe_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             fwd_we,
  input  logic             fwd_wdata,
  input  logic             sf_strobe,
  input  logic             nebe_i,
  output logic             febe_o
);

  febe_ctl_t ctl_cur;
  logic      fwd_cur;
  logic      fwd_consumed;

  febe_ctl_reg u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_q     (ctl_cur)
  );

  febe_fwd_bit #(.REST_VAL(1'b1)) u_fwd (
    .clk          (clk),
    .rst_n        (rst_n),
    .fwd_we       (fwd_we),
    .fwd_wdata    (fwd_wdata),
    .sf_strobe    (sf_strobe),
    .fwd_q        (fwd_cur),
    .fwd_consumed (fwd_consumed)
  );

  febe_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .sf_strobe (sf_strobe),
    .ctl       (ctl_cur),
    .nebe      (nebe_i),
    .fwd       (fwd_cur),
    .febe_q    (febe_o)
  );

  // R1: reset state of stored controls and output
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (febe_o && fwd_cur && (ctl_cur == CTL_RESET)));

  // R8: a consumed zero never survives into the next superframe
  p_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_consumed && !fwd_cur) |=> fwd_cur);

endmodule

// File: tb/febe_sel_test.sv
module febe_sel_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_we, fwd_we, fwd_wdata, sf_strobe, nebe_i;
  logic [2:0] ctl_wdata;
  logic       febe_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  febe_sel uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .fwd_we(fwd_we), .fwd_wdata(fwd_wdata), .sf_strobe(sf_strobe),
    .nebe_i(nebe_i), .febe_o(febe_o)
  );

  // Independent model: run AND (idle OR local term OR remote term)
  function automatic logic model(logic [2:0] c, logic n, logic f);
    logic r, rm, l;
    r = c[0]; rm = c[1]; l = c[2];
    return r & ((~l & ~rm) | (l & n) | (rm & f));
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: febe_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [2:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_fwd(logic v);
    @(negedge clk); fwd_we = 1'b1; fwd_wdata = v;
    @(negedge clk); fwd_we = 1'b0;
  endtask

  task automatic boundary(logic n);
    @(negedge clk); sf_strobe = 1'b1; nebe_i = n;
    @(negedge clk); sf_strobe = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ctl_we = 0; ctl_wdata = 0; fwd_we = 0; fwd_wdata = 0;
    sf_strobe = 0; nebe_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset output", febe_o, 1'b1);
    // R1: reset controls all 1 and fwd 1 -> OR gives 1 even with nebe 0
    boundary(1'b0);
    check("R1 reset controls", febe_o, 1'b1);

    // Exhaustive sweep R3 R4 R5 R6 R7
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 2; f++) begin
        for (int n = 0; n < 2; n++) begin
          wr_ctl(3'(c));
          wr_fwd(1'(f));
          boundary(1'(n));
          check($sformatf("R3/R4/R5/R6/R7 ctl=%0d fwd=%0d nebe=%0d", c, f, n),
                febe_o, model(3'(c), 1'(n), 1'(f)));
        end
      end
    end

    // R8: zero used once, then back to 1 unaided
    wr_ctl(3'b011);                 // run + remote only
    wr_fwd(1'b0);
    boundary(1'b0);
    check("R8 forwarded zero applied", febe_o, 1'b0);
    boundary(1'b0);
    check("R8 forwarded bit self-restored", febe_o, 1'b1);

    // R2: no strobe -> no change despite input and control changes
    wr_fwd(1'b0);
    boundary(1'b0);
    check("R2 setup", febe_o, 1'b0);
    @(negedge clk); nebe_i = 1'b1;
    wr_ctl(3'b000);
    repeat (4) @(negedge clk);
    check("R2 hold between strobes", febe_o, 1'b0);

    // R10: control write takes effect only at next boundary
    wr_ctl(3'b101);                 // run + local
    check("R10 before boundary", febe_o, 1'b0);
    boundary(1'b1);
    check("R10 after boundary", febe_o, 1'b1);

    // R9: write in same cycle as strobe
    wr_ctl(3'b011);
    @(negedge clk); sf_strobe = 1'b1; fwd_we = 1'b1; fwd_wdata = 1'b0; nebe_i = 1'b0;
    @(negedge clk); sf_strobe = 1'b0; fwd_we = 1'b0;
    check("R9 strobe used old value", febe_o, 1'b1);
    boundary(1'b0);
    check("R9 new value at following boundary", febe_o, 1'b0);
    boundary(1'b0);
    check("R9/R8 restored afterwards", febe_o, 1'b1);

    // R3: force low overrides both sources active
    wr_ctl(3'b110);
    boundary(1'b1);
    check("R3 forced low", febe_o, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule